// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Fill Reporting

This block carries a stream of data words from one clock domain into another. The producer side and the consumer side each use a valid/ready handshake, and each is clocked by its own clock. A word moves on a side only in a cycle where that side's valid and ready are both high. A producer that sees `in_ready` low must hold `in_valid` and `in_data` steady until the word is taken. The consumer may lower `out_ready` at any time. While it does, the offered word is held.

The producer side reports how many storage entries are still free (`in_room`). The consumer side reports how many entries hold data (`out_level`). Read and write positions cross the clock boundary as Gray-coded counts through a chain of flops. Each chain is reset by the reset of the domain that samples it. The parameter `OUT_MODE` chooses one of two output forms. In the direct form the consumer sees the storage slot itself. In the registered form one more flop stage sits in front of the consumer. That word has already left storage, so `out_level` reads one lower than the words actually held while the stage is full.

Top module: `async_stream_fifo`

## Requirements
- R1: Right after reset, on both sides, `in_ready` is 1, `in_room` equals the depth (2^ADDR_W), `out_valid` is 0 and `out_level` is 0.
- R2: Words are taken only on cycles with `in_valid` and `in_ready` both high. They are handed out only on cycles with `out_valid` and `out_ready` both high. Every accepted word leaves exactly once, unchanged and in acceptance order. Storage is never read while empty.
- R3: `in_ready` is low exactly when `in_room` is 0. With no reads, acceptance stops after the depth's worth of words has entered storage. While full, the write position does not move.
- R4: Once both sides have been idle for longer than the crossing latency, `in_room` equals the depth minus the number of words in storage.
- R5: Once both sides have been idle for longer than the crossing latency, `out_level` equals the number of words in storage.
- R6: In the direct form (OUT_MODE = OUT_DIRECT, value 0), `out_valid` is high exactly when `out_level` is nonzero.
- R7: In the registered form (OUT_MODE = OUT_REGISTERED, value 1), the word in the output stage is not counted by `out_level`. When settled, the words held equal `out_level` plus `out_valid`. The FIFO then holds up to depth+1 words.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the next consumer clock.
- R9: Positions cross domains as Gray codes, changing at most one bit per clock, through SYNC_STAGES flops. The first word written into an empty FIFO becomes visible after SYNC_STAGES consumer clocks in the direct form, and one consumer clock later in the registered form. A margin of up to two further clocks covers the clock phase.
- R10: `in_room` and `out_level` never exceed the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_clk | input | 1 | Producer-side clock |
| in_rst_n | input | 1 | Producer-side reset, active low, asynchronous assert |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | FIFO can take a word this cycle |
| in_data | input | DATA_W | Offered word |
| in_room | output | ADDR_W+1 | Free storage entries as seen by the producer side |
| out_clk | input | 1 | Consumer-side clock |
| out_rst_n | input | 1 | Consumer-side reset, active low, asynchronous assert |
| out_valid | output | 1 | A word is offered to the consumer |
| out_ready | input | 1 | Consumer takes the offered word this cycle |
| out_data | output | DATA_W | Offered word |
| out_level | output | ADDR_W+1 | Words in storage as seen by the consumer side |

## Verification
The bench builds two copies, each with 16-bit data, 16 entries (ADDR_W = 4) and two synchronizer stages. One copy uses the direct output form and the other the registered form, and both run on unrelated 250 MHz and roughly 143 MHz clocks. The small depth lets long bursts push the FIFO completely full and completely empty many times. That exercises the full/empty boundary with wrapped pointers, the depth+1 capacity of the registered form, and the one-word difference in its level. Idle pauses between random traffic phases let the counts settle so that they can be compared exactly against the reference queue.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;

  typedef enum logic {
    OUT_DIRECT     = 1'b0,
    OUT_REGISTERED = 1'b1
  } out_mode_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/afifo_wr_ctrl.sv
`timescale 1ns/1ps
module afifo_wr_ctrl
  import afifo_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              push_req,
  input  logic [ADDR_W:0]   rd_gray_async,
  output logic              push_ok,
  output logic [ADDR_W:0]   room,
  output logic [ADDR_W:0]   wr_gray,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr
);

  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] CAP = PW'(1) << ADDR_W;

  logic [PW-1:0] wbin, wbin_nx, rgray_s, rbin_s, used;
  logic          full, push;

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rd_sync (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rd_gray_async),
    .q     (rgray_s)
  );

  assign rbin_s    = PW'(gray_to_bin(32'(rgray_s)));
  assign used      = wbin - rbin_s;
  assign full      = (used == CAP);
  assign push_ok   = ~full;
  assign push      = push_req & ~full;
  assign room      = CAP - used;
  assign wbin_nx   = wbin + PW'(push);
  // storage is written whenever a free slot is addressed; only push moves on
  assign mem_we    = ~full;
  assign mem_waddr = wbin[ADDR_W-1:0];

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      wbin    <= '0;
      wr_gray <= '0;
    end else begin
      wbin    <= wbin_nx;
      wr_gray <= PW'(bin_to_gray(32'(wbin_nx)));
    end
  end

  assert_room_bound_R10: assert property (
    @(posedge wr_clk) disable iff (!wr_rst_n) room <= CAP);

  assert_gray_step_R9: assert property (
    @(posedge wr_clk) disable iff (!wr_rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1);

  assert_no_overflow_R3: assert property (
    @(posedge wr_clk) disable iff (!wr_rst_n)
    full |=> $stable(wr_gray));

endmodule

// File: rtl/afifo_rd_ctrl.sv
`timescale 1ns/1ps
module afifo_rd_ctrl
  import afifo_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              pop,
  input  logic [ADDR_W:0]   wr_gray_async,
  output logic              empty,
  output logic [ADDR_W:0]   level,
  output logic [ADDR_W:0]   rd_gray,
  output logic [ADDR_W-1:0] mem_raddr
);

  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] CAP = PW'(1) << ADDR_W;

  logic [PW-1:0] rbin, rbin_nx, wgray_s, wbin_s;

  afifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wr_sync (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wr_gray_async),
    .q     (wgray_s)
  );

  assign wbin_s    = PW'(gray_to_bin(32'(wgray_s)));
  assign level     = wbin_s - rbin;
  assign empty     = (level == '0);
  assign rbin_nx   = rbin + PW'(pop);
  assign mem_raddr = rbin[ADDR_W-1:0];

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rbin    <= '0;
      rd_gray <= '0;
    end else begin
      rbin    <= rbin_nx;
      rd_gray <= PW'(bin_to_gray(32'(rbin_nx)));
    end
  end

  assert_no_underflow_R2: assert property (
    @(posedge rd_clk) disable iff (!rd_rst_n) pop |-> !empty);

  assert_level_bound_R10: assert property (
    @(posedge rd_clk) disable iff (!rd_rst_n) level <= CAP);

  assert_gray_step_R9: assert property (
    @(posedge rd_clk) disable iff (!rd_rst_n)
    $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

// File: rtl/afifo_mem.sv
`timescale 1ns/1ps
module afifo_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4
) (
  input  logic              wr_clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];

endmodule

// File: rtl/afifo_out_stage.sv
`timescale 1ns/1ps
module afifo_out_stage
  import afifo_pkg::*;
#(
  parameter int        DATA_W   = 16,
  parameter out_mode_e OUT_MODE = OUT_REGISTERED
) (
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              mem_empty,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_pop,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data
);

  generate
    if (OUT_MODE == OUT_DIRECT) begin : g_direct
      assign m_valid = ~mem_empty;
      assign m_data  = mem_rdata;
      assign mem_pop = ~mem_empty & m_ready;
    end else begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;
      logic              load;

      assign load = ~mem_empty & (~vld_q | m_ready);

      always_ff @(posedge rd_clk or negedge rd_rst_n) begin
        if (!rd_rst_n)    vld_q <= 1'b0;
        else if (load)    vld_q <= 1'b1;
        else if (m_ready) vld_q <= 1'b0;
      end

      always_ff @(posedge rd_clk) begin
        if (load) dat_q <= mem_rdata;
      end

      assign mem_pop = load;
      assign m_valid = vld_q;
      assign m_data  = dat_q;
    end
  endgenerate

  assert_hold_R8: assert property (
    @(posedge rd_clk) disable iff (!rd_rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

endmodule

// File: rtl/async_stream_fifo.sv
`timescale 1ns/1ps
module async_stream_fifo
  import afifo_pkg::*;
#(
  parameter int        DATA_W      = 16,
  parameter int        ADDR_W      = 4,
  parameter int        SYNC_STAGES = 2,
  parameter out_mode_e OUT_MODE    = OUT_REGISTERED
) (
  input  logic              in_clk,
  input  logic              in_rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [ADDR_W:0]   in_room,
  input  logic              out_clk,
  input  logic              out_rst_n,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ADDR_W:0]   out_level
);

  logic [ADDR_W:0]   wr_gray, rd_gray;
  logic              mem_we, mem_empty, mem_pop;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] rdata;

  afifo_wr_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
    .wr_clk        (in_clk),
    .wr_rst_n      (in_rst_n),
    .push_req      (in_valid),
    .rd_gray_async (rd_gray),
    .push_ok       (in_ready),
    .room          (in_room),
    .wr_gray       (wr_gray),
    .mem_we        (mem_we),
    .mem_waddr     (waddr)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wr_clk (in_clk),
    .we     (mem_we),
    .waddr  (waddr),
    .wdata  (in_data),
    .raddr  (raddr),
    .rdata  (rdata)
  );

  afifo_rd_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rd (
    .rd_clk        (out_clk),
    .rd_rst_n      (out_rst_n),
    .pop           (mem_pop),
    .wr_gray_async (wr_gray),
    .empty         (mem_empty),
    .level         (out_level),
    .rd_gray       (rd_gray),
    .mem_raddr     (raddr)
  );

  afifo_out_stage #(.DATA_W(DATA_W), .OUT_MODE(OUT_MODE)) u_out (
    .rd_clk    (out_clk),
    .rd_rst_n  (out_rst_n),
    .mem_empty (mem_empty),
    .mem_rdata (rdata),
    .mem_pop   (mem_pop),
    .m_valid   (out_valid),
    .m_ready   (out_ready),
    .m_data    (out_data)
  );

endmodule

// File: tb/test_async_stream_fifo.sv
`timescale 1ns/1ps
module test_async_stream_fifo;

  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int SYNC  = 2;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst_n = 1'b0, rd_rst_n = 1'b0;
  logic [1:0] s_valid, s_ready, m_valid, m_ready;
  logic [DW-1:0] s_data [2];
  logic [DW-1:0] m_data [2];
  logic [AW:0]   room   [2];
  logic [AW:0]   level  [2];

  always #2   wr_clk = ~wr_clk;
  always #3.5 rd_clk = ~rd_clk;

  async_stream_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC),
                      .OUT_MODE(afifo_pkg::OUT_DIRECT)) i_async_stream_fifo (
    .in_clk(wr_clk), .in_rst_n(wr_rst_n), .in_valid(s_valid[0]), .in_ready(s_ready[0]),
    .in_data(s_data[0]), .in_room(room[0]),
    .out_clk(rd_clk), .out_rst_n(rd_rst_n), .out_valid(m_valid[0]), .out_ready(m_ready[0]),
    .out_data(m_data[0]), .out_level(level[0]));

  async_stream_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SYNC),
                      .OUT_MODE(afifo_pkg::OUT_REGISTERED)) i_async_stream_fifo_oreg (
    .in_clk(wr_clk), .in_rst_n(wr_rst_n), .in_valid(s_valid[1]), .in_ready(s_ready[1]),
    .in_data(s_data[1]), .in_room(room[1]),
    .out_clk(rd_clk), .out_rst_n(rd_rst_n), .out_valid(m_valid[1]), .out_ready(m_ready[1]),
    .out_data(m_data[1]), .out_level(level[1]));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  int unsigned wr_pct = 0, rd_pct = 0;
  logic [DW-1:0] sb [2][$];
  logic [1:0] acc = '0, lat_arm = '0, lat_done = '0, hold_prev = '0;
  int lat_cnt [2];
  logic [DW-1:0] hold_data [2];
  int wd = 0;

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input longint act, input longint lo, input longint hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic end_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // producer side: hold offers until taken, sample before the edge
  always begin
    @(negedge wr_clk);
    for (int k = 0; k < 2; k++) begin
      if (acc[k] || !s_valid[k]) begin
        s_valid[k] = ($urandom_range(99) < wr_pct);
        s_data[k]  = DW'($urandom);
      end
    end
    #1;
    for (int k = 0; k < 2; k++) begin
      if (wr_rst_n) begin
        chk_eq("R3 ready vs room", s_ready[k], room[k] != 0);
        chk_rng("R10 room bound", room[k], 0, DEPTH);
        acc[k] = s_valid[k] & s_ready[k];
        if (acc[k]) begin
          sb[k].push_back(s_data[k]);
          if (!lat_done[k]) begin
            lat_done[k] = 1'b1;
            lat_arm[k]  = 1'b1;
            lat_cnt[k]  = 0;
          end
        end
      end else begin
        acc[k] = 1'b0;
      end
    end
  end

  // consumer side: random ready, compare against reference queue
  always begin
    @(negedge rd_clk);
    for (int k = 0; k < 2; k++) m_ready[k] = ($urandom_range(99) < rd_pct);
    #1;
    if (rd_rst_n) begin
      for (int k = 0; k < 2; k++) begin
        if (hold_prev[k]) begin
          chk_eq("R8 valid held", m_valid[k], 1);
          chk_eq("R8 data held", m_data[k], hold_data[k]);
        end
        if (k == 0) chk_eq("R6 valid vs level", m_valid[0], level[0] != 0);
        chk_rng("R10 level bound", level[k], 0, DEPTH);
        if (lat_arm[k]) begin
          if (m_valid[k]) begin
            chk_rng("R9 crossing latency", lat_cnt[k], SYNC - 1 + k, SYNC + 2 + k);
            lat_arm[k] = 1'b0;
          end else begin
            lat_cnt[k]++;
          end
        end
        if (m_valid[k] && m_ready[k]) begin
          if (sb[k].size() == 0) chk_eq("R2 unexpected word", 1, 0);
          else chk_eq("R2 data order", m_data[k], sb[k].pop_front());
        end
        hold_prev[k] = m_valid[k] & ~m_ready[k];
        hold_data[k] = m_data[k];
      end
    end
  end

  always @(posedge wr_clk) begin
    wd++;
    if (wd > 150000) begin
      chk_eq("watchdog expired", 1, 0);
      end_run();
    end
  end

  task automatic settle_check();
    wr_pct = 0;
    rd_pct = 0;
    repeat (40) @(posedge rd_clk);
    @(negedge rd_clk);
    #2;
    for (int k = 0; k < 2; k++) begin
      int stored;
      stored = sb[k].size() - ((k == 1) ? int'(m_valid[k]) : 0);
      chk_eq("R4 settled room", room[k], DEPTH - stored);
      if (k == 0) chk_eq("R5 settled level", level[k], stored);
      else        chk_eq("R7 level plus stage", level[k] + m_valid[k], sb[k].size());
    end
  endtask

  initial begin
    s_valid = '0;
    m_ready = '0;
    s_data[0] = '0; s_data[1] = '0;
    #26;
    wr_rst_n = 1'b1;
    rd_rst_n = 1'b1;
    #1;
    for (int k = 0; k < 2; k++) begin
      chk_eq("R1 reset ready", s_ready[k], 1);
      chk_eq("R1 reset room", room[k], DEPTH);
      chk_eq("R1 reset valid", m_valid[k], 0);
      chk_eq("R1 reset level", level[k], 0);
    end

    // fill with no reads
    wr_pct = 100; rd_pct = 0;
    repeat (120) @(posedge wr_clk);
    settle_check();
    for (int k = 0; k < 2; k++) begin
      chk_eq("R3 full room", room[k], 0);
      chk_eq("R3 full ready", s_ready[k], 0);
      chk_eq("R7 capacity", sb[k].size(), DEPTH + k);
    end

    // drain with no writes
    wr_pct = 0; rd_pct = 100;
    repeat (120) @(posedge rd_clk);
    settle_check();
    for (int k = 0; k < 2; k++) begin
      chk_eq("R2 all words out", sb[k].size(), 0);
      chk_eq("R5 empty level", level[k], 0);
      chk_eq("R4 empty room", room[k], DEPTH);
    end

    // mixed traffic
    for (int ph = 0; ph < 3; ph++) begin
      wr_pct = (ph == 0) ? 50 : (ph == 1) ? 90 : 30;
      rd_pct = (ph == 0) ? 50 : (ph == 1) ? 30 : 90;
      repeat (2500) @(posedge wr_clk);
      settle_check();
    end

    wr_pct = 0; rd_pct = 100;
    repeat (200) @(posedge rd_clk);
    settle_check();
    for (int k = 0; k < 2; k++) chk_eq("R2 final drain", sb[k].size(), 0);
    end_run();
  end

endmodule